// File: doc/BRIEF.md
# Core power-state handshake controller

This block moves a processor core between three power levels: full-on, halted and stopped. System power logic asks for each level by raising request lines. The block answers with acknowledge outputs only after the core has reached the level that was asked for. Going down, the block first stops instruction issue. It then waits for the pipeline to drain before it reports halted. For a stop, it waits for the bus interface to go idle, then gates the functional-unit clocks, and only after that reports stopped.

A stopped core cannot snoop. When system logic lowers the stop request while keeping halt raised, the block makes a short trip back to the halted level. Clocks run again, the stopped acknowledge drops, and snoop acceptance opens one cycle later. Once the snoop work is reported done, the block returns to stopped by itself, through the same idle-wait and clock-gating steps. The block also passes the doze, nap and sleep request bits to the system, each qualified by a wait-enable bit. It passes the time-base enable straight through.

Top module: `core_pwr_seq`

## Requirements
- R1: After reset: unit_clk_en=1, issue_en=1, snoop_en=1, halted_ack=0, stopped_ack=0.
- R2: A halt_req sampled high in full-on clears issue_en at the next clock edge. halted_ack stays 0 until pipe_drained is sampled high, and rises at the edge that samples it. halted_ack is never 1 while issue_en is 1.
- R3: While halted and not on the stop path, unit_clk_en=1 and snoop_en=1.
- R4: A stop_req sampled high is acted on only when the core is already halted. In full-on it leaves all outputs at their full-on values.
- R5: With halt_req and stop_req high in halted, the block waits for bus_idle. At the edge that samples bus_idle high, unit_clk_en goes to 0. stopped_ack rises GATE_CYCLES edges after that.
- R6: While stopped_ack=1, snoop_en=0 and unit_clk_en=0.
- R7: A falling edge of stop_req while stopped, with halt_req high, gives stopped_ack=0 and unit_clk_en=1 at the next edge, with snoop_en still 0. snoop_en becomes 1 one edge later, with halted_ack=1.
- R8: During that snoop excursion, snoop_done sampled high starts the return to stopped without any new stop_req. The return goes through the same bus-idle and GATE_CYCLES sequence as R5.
- R9: doze_out = wait_en & doze_req, nap_out = wait_en & nap_req and sleep_out = wait_en & sleep_req, combinationally, in every state.
- R10: tb_tick_en equals tb_en combinationally in every state.
- R11: halt_req sampled low in halted or stopped returns the block to full-on. From halted, issue_en=1 and halted_ack=0 at the next edge. From stopped, the next edge gives stopped_ack=0 and the one after gives issue_en=1.
- R12: stopped_ack is 0 at every edge that follows a cycle with halt_req low. With halt_req low, stop_req is ignored until halt_req is raised again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| halt_req | input | 1 | Halt request from system power logic |
| stop_req | input | 1 | Stop request from system power logic |
| bus_idle | input | 1 | Bus interface has no transaction in flight |
| pipe_drained | input | 1 | Pipeline has no instruction in flight |
| snoop_pend | input | 1 | A snoop is waiting to be serviced |
| snoop_done | input | 1 | Snoop and its response or copy-back work finished |
| wait_en | input | 1 | Wait-enable control bit |
| doze_req | input | 1 | Doze request bit |
| nap_req | input | 1 | Nap request bit |
| sleep_req | input | 1 | Sleep request bit |
| tb_en | input | 1 | Time-base enable |
| halted_ack | output | 1 | Core is halted |
| stopped_ack | output | 1 | Core is stopped |
| unit_clk_en | output | 1 | Functional-unit clock enable |
| issue_en | output | 1 | Instruction-issue enable |
| snoop_en | output | 1 | Snoop acceptance enable |
| doze_out | output | 1 | Doze indication to the system |
| nap_out | output | 1 | Nap indication to the system |
| sleep_out | output | 1 | Sleep indication to the system |
| tb_tick_en | output | 1 | Time-base tick enable |

## Verification
The bench builds the block with GATE_CYCLES=3. At that value the gap between clock gating and the stopped acknowledge spans several edges, so a stopped acknowledge that comes early or late shows up as a wrong cycle count. Drain and bus-idle waits get random lengths from a fixed seed. The qualified indications and the time-base enable are driven randomly in full-on, halted and stopped states, so every state is covered for those outputs.

// File: rtl/core_pwr_seq.sv
module core_pwr_seq #(
  parameter int GATE_CYCLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic halt_req,
  input  logic stop_req,
  input  logic bus_idle,
  input  logic pipe_drained,
  input  logic snoop_pend,
  input  logic snoop_done,
  input  logic wait_en,
  input  logic doze_req,
  input  logic nap_req,
  input  logic sleep_req,
  input  logic tb_en,
  output logic halted_ack,
  output logic stopped_ack,
  output logic unit_clk_en,
  output logic issue_en,
  output logic snoop_en,
  output logic doze_out,
  output logic nap_out,
  output logic sleep_out,
  output logic tb_tick_en
);
  localparam int CW = (GATE_CYCLES < 2) ? 1 : $clog2(GATE_CYCLES);
  localparam logic [CW-1:0] CNT_LAST = CW'(GATE_CYCLES - 1);

  typedef enum logic [2:0] {
    S_FULL, S_DRAIN, S_HALT, S_STOPW, S_GATE, S_STOP, S_WAKE, S_EXCUR
  } st_t;

  st_t st, nx;
  logic [CW-1:0] cnt;
  logic stop_q;
  logic stop_fall;

  assign stop_fall = stop_q & ~stop_req;

  always_comb begin
    nx = st;
    unique case (st)
      S_FULL:  if (halt_req) nx = S_DRAIN;
      S_DRAIN: if (!halt_req) nx = S_FULL;
               else if (pipe_drained) nx = S_HALT;
      S_HALT:  if (!halt_req) nx = S_FULL;
               else if (stop_req) nx = S_STOPW;
      S_STOPW: if (!halt_req) nx = S_FULL;
               else if (stop_fall) nx = S_HALT;
               else if (bus_idle) nx = S_GATE;
      S_GATE:  if (!halt_req || stop_fall) nx = S_WAKE;
               else if (cnt == CNT_LAST) nx = S_STOP;
      S_STOP:  if (!halt_req || stop_fall) nx = S_WAKE;
      S_WAKE:  nx = halt_req ? S_EXCUR : S_FULL;
      S_EXCUR: if (!halt_req) nx = S_FULL;
               else if (snoop_done || (stop_req && !snoop_pend)) nx = S_STOPW;
      default: nx = S_FULL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_FULL;
      cnt    <= '0;
      stop_q <= 1'b0;
    end else begin
      st     <= nx;
      stop_q <= stop_req;
      if (nx == S_GATE && st == S_GATE) cnt <= cnt + 1'b1;
      else cnt <= '0;
    end
  end

  always_comb begin
    {issue_en, unit_clk_en, snoop_en, halted_ack, stopped_ack} = 5'b11100;
    unique case (st)
      S_FULL:  {issue_en, unit_clk_en, snoop_en, halted_ack, stopped_ack} = 5'b11100;
      S_DRAIN: {issue_en, unit_clk_en, snoop_en, halted_ack, stopped_ack} = 5'b01100;
      S_HALT,
      S_STOPW,
      S_EXCUR: {issue_en, unit_clk_en, snoop_en, halted_ack, stopped_ack} = 5'b01110;
      S_GATE:  {issue_en, unit_clk_en, snoop_en, halted_ack, stopped_ack} = 5'b00010;
      S_STOP:  {issue_en, unit_clk_en, snoop_en, halted_ack, stopped_ack} = 5'b00011;
      S_WAKE:  {issue_en, unit_clk_en, snoop_en, halted_ack, stopped_ack} = 5'b01010;
      default: {issue_en, unit_clk_en, snoop_en, halted_ack, stopped_ack} = 5'b11100;
    endcase
  end

  assign doze_out   = wait_en & doze_req;
  assign nap_out    = wait_en & nap_req;
  assign sleep_out  = wait_en & sleep_req;
  assign tb_tick_en = tb_en;
endmodule

module core_pwr_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic halt_req,
  input logic halted_ack,
  input logic stopped_ack,
  input logic unit_clk_en,
  input logic issue_en,
  input logic snoop_en
);
  // R2
  halt_no_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted_ack |-> !issue_en);
  // R2
  halt_after_issue_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halted_ack) |-> !$past(issue_en));
  // R5
  gate_before_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stopped_ack) |-> !$past(unit_clk_en));
  // R6
  stop_no_snoop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stopped_ack |-> (!snoop_en && !unit_clk_en));
  // R7
  wake_snoop_late_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stopped_ack) |-> !snoop_en);
  // R12
  no_stop_unhalted_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !halt_req |=> !stopped_ack);
endmodule

bind core_pwr_seq core_pwr_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .halted_ack(halted_ack),
  .stopped_ack(stopped_ack), .unit_clk_en(unit_clk_en), .issue_en(issue_en),
  .snoop_en(snoop_en)
);

// File: tb/sim_core_pwr_seq.sv
`timescale 1ns/1ps
module sim_core_pwr_seq;
  localparam int GC = 3;
  logic clk = 1'b0, rst_n = 1'b0;
  logic halt_req = 0, stop_req = 0, bus_idle = 0, pipe_drained = 0;
  logic snoop_pend = 0, snoop_done = 0, wait_en = 0;
  logic doze_req = 0, nap_req = 0, sleep_req = 0, tb_en = 0;
  logic halted_ack, stopped_ack, unit_clk_en, issue_en, snoop_en;
  logic doze_out, nap_out, sleep_out, tb_tick_en;
  int total = 0, bad = 0;

  core_pwr_seq #(.GATE_CYCLES(GC)) u0 (
    .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .stop_req(stop_req),
    .bus_idle(bus_idle), .pipe_drained(pipe_drained), .snoop_pend(snoop_pend),
    .snoop_done(snoop_done), .wait_en(wait_en), .doze_req(doze_req),
    .nap_req(nap_req), .sleep_req(sleep_req), .tb_en(tb_en),
    .halted_ack(halted_ack), .stopped_ack(stopped_ack), .unit_clk_en(unit_clk_en),
    .issue_en(issue_en), .snoop_en(snoop_en), .doze_out(doze_out),
    .nap_out(nap_out), .sleep_out(sleep_out), .tb_tick_en(tb_tick_en)
  );

  always #4 clk = ~clk;

  function automatic logic [4:0] exp_ctl(input logic iss, clk_on, snp, h, s);
    return {iss, clk_on, snp, h, s};
  endfunction

  function automatic logic [3:0] exp_misc(input logic w, d, n, s, t);
    return {w & d, w & n, w & s, t};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic chk_ctl(input string req, input logic [4:0] exp);
    chk(req, {27'd0, issue_en, unit_clk_en, snoop_en, halted_ack, stopped_ack}, {27'd0, exp});
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic rand_misc(input string req, input int n);
    for (int i = 0; i < n; i++) begin
      {wait_en, doze_req, nap_req, sleep_req, tb_en} = 5'($urandom);
      #1;
      chk(req, {28'd0, doze_out, nap_out, sleep_out, tb_tick_en},
          {28'd0, exp_misc(wait_en, doze_req, nap_req, sleep_req, tb_en)});
    end
  endtask

  initial begin
    #(8 * 200000);
    bad++; total++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int w;
    void'($urandom(32'h5eed));
    tick(3);
    // R1 reset state
    chk_ctl("R1", exp_ctl(1,1,1,0,0));
    @(negedge clk); rst_n = 1'b1;
    tick(1);
    chk_ctl("R1", exp_ctl(1,1,1,0,0));
    rand_misc("R9 R10 full", 40);

    // R2 halt entry with random drain length
    @(negedge clk); halt_req = 1;
    tick(1);
    chk_ctl("R2", exp_ctl(0,1,1,0,0));
    w = int'($urandom_range(1, 4));
    tick(w);
    chk_ctl("R2", exp_ctl(0,1,1,0,0));
    @(negedge clk); pipe_drained = 1;
    tick(1);
    // R3
    chk_ctl("R2 R3", exp_ctl(0,1,1,1,0));
    rand_misc("R9 R10 halted", 40);

    // R11 halt drop from halted
    @(negedge clk); halt_req = 0;
    tick(1);
    chk_ctl("R11", exp_ctl(1,1,1,0,0));

    // R12 and R4: stop with halt low is ignored
    @(negedge clk); stop_req = 1;
    tick(4);
    chk_ctl("R4 R12", exp_ctl(1,1,1,0,0));

    // R5 halt reasserted, stop acted on, wait for bus idle
    @(negedge clk); halt_req = 1;
    tick(2);
    chk_ctl("R12", exp_ctl(0,1,1,1,0));
    w = int'($urandom_range(2, 6));
    tick(w);
    chk_ctl("R5", exp_ctl(0,1,1,1,0));
    @(negedge clk); bus_idle = 1;
    tick(1);
    chk_ctl("R5", exp_ctl(0,0,0,1,0));
    tick(GC - 1);
    chk_ctl("R5", exp_ctl(0,0,0,1,0));
    tick(1);
    // R6
    chk_ctl("R5 R6", exp_ctl(0,0,0,1,1));
    rand_misc("R9 R10 stopped", 40);

    // R7 snoop excursion
    @(negedge clk); stop_req = 0;
    tick(1);
    chk_ctl("R7", exp_ctl(0,1,0,1,0));
    tick(1);
    chk_ctl("R7", exp_ctl(0,1,1,1,0));
    @(negedge clk); snoop_pend = 1;
    tick(2);
    chk_ctl("R7", exp_ctl(0,1,1,1,0));
    // R8 automatic return
    @(negedge clk); snoop_done = 1;
    tick(1);
    chk_ctl("R8", exp_ctl(0,1,1,1,0));
    @(negedge clk); snoop_done = 0; snoop_pend = 0;
    chk_ctl("R8", exp_ctl(0,1,1,1,0));
    tick(1);
    chk_ctl("R8", exp_ctl(0,0,0,1,0));
    tick(GC - 1);
    chk_ctl("R8", exp_ctl(0,0,0,1,0));
    tick(1);
    chk_ctl("R8", exp_ctl(0,0,0,1,1));

    // R11 halt drop from stopped
    @(negedge clk); halt_req = 0;
    tick(1);
    chk_ctl("R11 R12", exp_ctl(0,1,0,1,0));
    tick(1);
    chk_ctl("R11", exp_ctl(1,1,1,0,0));
    rand_misc("R9 R10 end", 40);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule